// File: doc/BRIEF.md
# Cipher Engine Power-Up Self-Test Gate

This controller stands between a storage cipher engine and the system around it. Every release of reset starts it on its own, with no software action. It runs a fixed pair of known-answer tests through the cipher core: first an encryption under a 256-bit key, then a decryption under the same key. Each test drives a constant key and a constant 128-bit block into the core. It waits for the core's done strobe, then compares the full 128-bit answer with a stored constant.

When both answers match, the controller raises a registered availability flag and opens the input and output data gates. A single wrong bit in either answer locks the engine. In the locked state the gates stay shut and the core's strobes are ignored. Only a new reset clears the lock, and that reset runs the whole sequence again. While tests are running, the data output and data input gates stay closed. No input can open them early or route data around the cipher.

Top module: `ste_gate_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it: `avail_o`=0, `din_en_o`=0, `dout_en_o`=0, `status_o`=2'b01 (testing).
- R2: With no other input, the first test strobe after reset carries `kat_decrypt_o`=0, the key 000102..1f (bytes ascending) and the block 00112233445566778899aabbccddeeff.
- R3: The decryption test comes second. It is issued only after the encryption answer matched. It carries `kat_decrypt_o`=1 and the block 8ea2b7ca516745bfeafc49904b496089, under the same key.
- R4: If both answers match (encryption expects the R3 block, decryption expects the R2 block), then `status_o`=2'b10 (passed), `avail_o`=1, and both gates are 1.
- R5: A mismatch in any single bit of the encryption answer gives `status_o`=2'b11 (failed) and `avail_o`=0, and no decryption test is issued.
- R6: A mismatch in the decryption answer gives `status_o`=2'b11 and `avail_o`=0.
- R7: The failed state is sticky. Further done strobes, whatever their data, change nothing. A reset clears it and re-runs both tests.
- R8: If the fault is still there after a reset, the engine fails again and stays unavailable.
- R9: `din_en_o` and `dout_en_o` are 1 only while `status_o`=2'b10. They are low throughout testing and the failed state.
- R10: `kat_start_o` is a one-cycle pulse, issued once per test. Each test waits for `core_done_i`, however many cycles the core takes.
- R11: A done strobe in the passed state is ignored, and the engine stays available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kat_start_o | output | 1 | One-cycle strobe that starts a test on the cipher core |
| kat_decrypt_o | output | 1 | Direction of the test: 0 encrypt, 1 decrypt |
| kat_key_o | output | 256 | Test key |
| kat_block_o | output | 128 | Test input block |
| core_done_i | input | 1 | Core answer valid strobe |
| core_result_i | input | 128 | Core answer |
| avail_o | output | 1 | Engine released for service |
| status_o | output | 2 | 01 testing, 10 passed, 11 failed |
| din_en_o | output | 1 | Data input gate enable |
| dout_en_o | output | 1 | Data output gate enable |

## Verification
The hardest state to reach from the ports is a failure in the second test after a correct first one. A bench model of the cipher core reaches it: the model answers each strobe correctly but XORs a separate error mask into the encryption or the decryption result. Done strobes can also be injected while the engine is locked or available, to show that those states ignore them. Running the model with zero and with long response latency checks that the controller waits for the core, not for a fixed count.

// File: rtl/ste_pkg.sv
package ste_pkg;
  localparam int BLK_W = 128;
  localparam int KEY_W = 256;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_ISSUE,
    ST_WAIT,
    ST_OPER,
    ST_LOCK
  } ste_state_e;

  localparam logic [1:0] STS_TESTING = 2'b01;
  localparam logic [1:0] STS_PASSED  = 2'b10;
  localparam logic [1:0] STS_FAILED  = 2'b11;

  localparam logic [KEY_W-1:0] KAT_KEY =
    256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
  localparam logic [BLK_W-1:0] KAT_PLAIN  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [BLK_W-1:0] KAT_CIPHER = 128'h8ea2b7ca516745bfeafc49904b496089;
endpackage

// File: rtl/ste_kat_rom.sv
module ste_kat_rom
  import ste_pkg::*;
#(
  parameter int IDX_W = 1
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic             decrypt_o,
  output logic [BLK_W-1:0] block_o,
  output logic [BLK_W-1:0] expect_o
);
  // Even slots encrypt, odd slots decrypt: encryption always precedes.
  always_comb begin
    decrypt_o = idx_i[0];
    if (idx_i[0]) begin
      block_o  = KAT_CIPHER;
      expect_o = KAT_PLAIN;
    end else begin
      block_o  = KAT_PLAIN;
      expect_o = KAT_CIPHER;
    end
  end
endmodule

// File: rtl/ste_result_cmp.sv
module ste_result_cmp
  import ste_pkg::*;
(
  input  logic [BLK_W-1:0] result_i,
  input  logic [BLK_W-1:0] expect_i,
  output logic             match_o
);
  logic [BLK_W-1:0] diff;
  always_comb begin
    diff    = result_i ^ expect_i;
    match_o = (diff == '0);
  end
endmodule

// File: rtl/ste_gate_ctrl.sv
module ste_gate_ctrl
  import ste_pkg::*;
#(
  parameter int NUM_TESTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             kat_start_o,
  output logic             kat_decrypt_o,
  output logic [KEY_W-1:0] kat_key_o,
  output logic [BLK_W-1:0] kat_block_o,
  input  logic             core_done_i,
  input  logic [BLK_W-1:0] core_result_i,
  output logic             avail_o,
  output logic [1:0]       status_o,
  output logic             din_en_o,
  output logic             dout_en_o
);
  localparam int IDX_W = (NUM_TESTS > 1) ? $clog2(NUM_TESTS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TESTS - 1);

  ste_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             avail_q, avail_d;
  logic [1:0]       sts_q, sts_d;
  logic [BLK_W-1:0] expect_w;
  logic             match_w;

  ste_kat_rom #(.IDX_W(IDX_W)) u_rom (
    .idx_i     (idx_q),
    .decrypt_o (kat_decrypt_o),
    .block_o   (kat_block_o),
    .expect_o  (expect_w)
  );

  ste_result_cmp u_cmp (
    .result_i (core_result_i),
    .expect_i (expect_w),
    .match_o  (match_w)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_BOOT: begin
        idx_d   = '0;
        state_d = ST_ISSUE;
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (core_done_i) begin
          if (!match_w)              state_d = ST_LOCK;
          else if (idx_q == LAST_IDX) state_d = ST_OPER;
          else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_ISSUE;
          end
        end
      end
      ST_OPER: state_d = ST_OPER;
      ST_LOCK: state_d = ST_LOCK;
      default: state_d = ST_LOCK;
    endcase
  end

  always_comb begin
    avail_d = (state_d == ST_OPER);
    if (state_d == ST_OPER)      sts_d = STS_PASSED;
    else if (state_d == ST_LOCK) sts_d = STS_FAILED;
    else                         sts_d = STS_TESTING;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOT;
      idx_q   <= '0;
      avail_q <= 1'b0;
      sts_q   <= STS_TESTING;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      avail_q <= avail_d;
      sts_q   <= sts_d;
    end
  end

  assign kat_start_o = (state_q == ST_ISSUE);
  assign kat_key_o   = KAT_KEY;
  assign avail_o     = avail_q;
  assign status_o    = sts_q;
  assign din_en_o    = avail_q;
  assign dout_en_o   = avail_q;

  // Gates open only in the passed state (R9)
  p_gate_passed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (din_en_o || dout_en_o) |-> (status_o == STS_PASSED));

  // Lock holds until reset (R7)
  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == STS_FAILED) |=> (status_o == STS_FAILED) && !avail_o);

  // Start is a single-cycle pulse (R10)
  p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    kat_start_o |=> !kat_start_o);

  // Availability only follows an accepted decryption answer (R4)
  p_avail_after_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(avail_o) |-> $past(core_done_i && kat_decrypt_o));

  // Passed state never leaves without reset (R11)
  p_oper_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == STS_PASSED) |=> (status_o == STS_PASSED) && avail_o);
endmodule

// File: tb/ste_gate_ctrl_test.sv
`timescale 1ns/1ps
module ste_gate_ctrl_test;
  import ste_pkg::*;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             kat_start, kat_decrypt, avail, din_en, dout_en;
  logic [KEY_W-1:0] kat_key;
  logic [BLK_W-1:0] kat_block;
  logic [1:0]       status;
  logic             core_done;
  logic [BLK_W-1:0] core_result;

  always #2 clk = ~clk;

  ste_gate_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .kat_start_o(kat_start), .kat_decrypt_o(kat_decrypt),
    .kat_key_o(kat_key), .kat_block_o(kat_block),
    .core_done_i(core_done), .core_result_i(core_result),
    .avail_o(avail), .status_o(status),
    .din_en_o(din_en), .dout_en_o(dout_en)
  );

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  // Cipher core model
  int               lat = 0;
  logic [BLK_W-1:0] mask_enc = '0, mask_dec = '0;
  logic             pend, stub_done, stub_op;
  logic [BLK_W-1:0] stub_blk, stub_res;
  int               cnt;
  logic             inj_done = 1'b0;
  logic [BLK_W-1:0] inj_res = '0;

  int               starts;
  logic             log_dec [2];
  logic [BLK_W-1:0] log_blk [2];
  logic [KEY_W-1:0] log_key [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; stub_done <= 1'b0; cnt <= 0; stub_res <= '0;
      stub_op <= 1'b0; stub_blk <= '0;
    end else begin
      stub_done <= 1'b0;
      if (kat_start) begin
        pend <= 1'b1; cnt <= lat; stub_op <= kat_decrypt; stub_blk <= kat_block;
      end else if (pend) begin
        if (cnt == 0) begin
          pend      <= 1'b0;
          stub_done <= 1'b1;
          if (!stub_op) stub_res <= ((stub_blk == KAT_PLAIN) ? KAT_CIPHER : '0) ^ mask_enc;
          else          stub_res <= ((stub_blk == KAT_CIPHER) ? KAT_PLAIN : '0) ^ mask_dec;
        end else cnt <= cnt - 1;
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n && kat_start) begin
      if (starts < 2) begin
        log_dec[starts] <= kat_decrypt;
        log_blk[starts] <= kat_block;
        log_key[starts] <= kat_key;
      end
      starts <= starts + 1;
    end
  end

  assign core_done   = stub_done | inj_done;
  assign core_result = inj_done ? inj_res : stub_res;

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    starts = 0;
    repeat (3) @(negedge clk);
    chk(status == STS_TESTING && !avail && !din_en && !dout_en, "R1 in reset",
        {avail, din_en, dout_en, status}, {3'b000, STS_TESTING});
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == STS_TESTING && !avail && !din_en && !dout_en, "R1 after release",
        {avail, din_en, dout_en, status}, {3'b000, STS_TESTING});
  endtask

  // Waits for the test sequence to settle; gates must stay shut meanwhile (R9)
  task automatic settle();
    int leaks = 0;
    int n = 0;
    while (status == STS_TESTING && n < 300) begin
      if (din_en || dout_en || avail) leaks++;
      @(negedge clk);
      n++;
    end
    chk(n < 300, "R10 sequence settles", n, 300);
    chk(leaks == 0, "R9 gates shut while testing", leaks, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic inject(input logic [BLK_W-1:0] val);
    inj_res = val;
    inj_done = 1'b1;
    @(negedge clk);
    inj_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_pass(input int l);
    lat = l; mask_enc = '0; mask_dec = '0;
    do_reset();
    settle();
    chk(status == STS_PASSED && avail && din_en && dout_en, "R4 passed",
        {avail, din_en, dout_en, status}, {3'b111, STS_PASSED});
    chk(starts == 2, "R10 one strobe per test", starts, 2);
    chk(!log_dec[0] && log_blk[0] == KAT_PLAIN && log_key[0] == KAT_KEY, "R2 first test",
        log_blk[0], KAT_PLAIN);
    chk(log_dec[1] && log_blk[1] == KAT_CIPHER && log_key[1] == KAT_KEY, "R3 second test",
        log_blk[1], KAT_CIPHER);
  endtask

  task automatic t_idle_done();
    inject('0);
    inject(KAT_PLAIN ^ 128'h1);
    chk(status == STS_PASSED && avail && dout_en, "R11 stray done ignored",
        {avail, status}, {1'b1, STS_PASSED});
  endtask

  task automatic t_enc_fail(input int b);
    lat = 2; mask_enc = '0; mask_enc[b] = 1'b1; mask_dec = '0;
    do_reset();
    settle();
    chk(status == STS_FAILED && !avail && !din_en && !dout_en, "R5 enc mismatch",
        {avail, din_en, dout_en, status}, {3'b000, STS_FAILED});
    chk(starts == 1, "R5 no decryption issued", starts, 1);
  endtask

  task automatic t_dec_fail();
    lat = 1; mask_enc = '0; mask_dec = '0; mask_dec[64] = 1'b1;
    do_reset();
    settle();
    chk(status == STS_FAILED && !avail && !dout_en, "R6 dec mismatch",
        {avail, status}, {1'b0, STS_FAILED});
    chk(starts == 2, "R6 both tests issued", starts, 2);
  endtask

  task automatic t_sticky();
    int s0;
    t_enc_fail(5);
    s0 = starts;
    inject(KAT_CIPHER);
    inject(KAT_PLAIN);
    repeat (20) @(negedge clk);
    chk(status == STS_FAILED && !avail && !din_en && !dout_en && starts == s0,
        "R7 lock ignores strobes", {avail, status}, {1'b0, STS_FAILED});
    mask_enc = '0;
    do_reset();
    settle();
    chk(status == STS_PASSED && avail, "R7 reset reruns and passes",
        {avail, status}, {1'b1, STS_PASSED});
  endtask

  task automatic t_recur();
    for (int k = 0; k < 2; k++) begin
      lat = 3; mask_dec = '0; mask_dec[127] = 1'b1;
      do_reset();
      settle();
      chk(status == STS_FAILED && !avail && !dout_en, "R8 fault persists",
          {avail, status}, {1'b0, STS_FAILED});
    end
  endtask

  initial begin
    rst_n = 1'b0;
    t_pass(0);
    t_idle_done();
    t_pass(7);
    t_enc_fail(0);
    t_enc_fail(127);
    t_dec_fail();
    t_sticky();
    t_recur();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    summary();
  end
endmodule